// File: doc/BRIEF.md
# Fault-Driven Refill Way Picker

This block sits next to a set-associative translation buffer. When a lookup fails, it decides which of the buffer's ways the refill handler should overwrite. It also records what went wrong so that the handler can read it. It does not perform the lookup and it does not write the refill entry. It only reacts to a single-cycle fault strobe.

The strobe carries five pieces of information:
- the access kind (read, write or execute);
- the faulting virtual page number;
- the current process identifier;
- a flag that tells a real miss apart from a permission fault on an entry that did hit;
- the way that hit.

On a real miss, the way comes from a 16-bit pseudo-random shift register. On a permission fault, the way is the one that hit, so that the handler rewrites the offending entry. The shift register steps on every fault and on nothing else. The sequence of chosen ways therefore depends only on how many faults have occurred.

Two status words are updated on the fault edge:
- the selection word holds the set index and the chosen way;
- the cause word holds the page number, the access kind and the process identifier.

Top module: `refill_way_picker`

## Requirements
- R1: While rst_n is low at a clock edge, rand_state_o becomes 0xCCCC, and sel_o and cause_o become zero.
- R2: On a fault edge, the shift register moves right by one position. The new bit 15 is the XOR of the current bits 15, 11, 2 and 0 (mask 0x8805). The width stays 16 bits.
- R3: On an edge with fault_i low, rand_state_o keeps its value.
- R4: On a fault with prot_fault_i low (a real miss), the way written to sel_o[5:4] equals rand_state_o[1:0] as it was before that edge.
- R5: On a fault with prot_fault_i high, the way written to sel_o[5:4] equals hit_way_i, whatever the shift register holds. The shift register still steps.
- R6: On a fault, sel_o[3:0] takes vpn_i[3:0] and sel_o bits 31:6 become zero.
- R7: On a fault, cause_o[31:13] takes vpn_i, cause_o[9:8] takes acc_kind_i (0 read, 1 write, 2 execute), and cause_o[7:0] takes pid_i.
- R8: cause_o[12:10] is never changed by a fault and so stays at its reset value of zero. On an edge with fault_i low, sel_o and cause_o keep their values.
- R9: Faults on consecutive cycles each update all three registers. Every one of them uses the shift register value left by the previous fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_i | input | 1 | One-cycle fault strobe |
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| vpn_i | input | 19 | Faulting virtual page number |
| pid_i | input | 8 | Current process identifier |
| prot_fault_i | input | 1 | 1 = permission fault on a hit entry, 0 = real miss |
| hit_way_i | input | 2 | Way that hit (used when prot_fault_i is 1) |
| sel_o | output | 32 | Selection word: index [3:0], way [5:4] |
| cause_o | output | 32 | Cause word: pid [7:0], kind [9:8], page [31:13] |
| rand_state_o | output | 16 | Current shift register value |

## Verification
The hardest case to reach is a permission fault where the hit way differs from the low bits of the shift register. Only that case can tell the two sources of the way apart. The stimulus first walks the register through many misses, so that its low bits cover all four values. It then sends permission faults with each of the four hit-way values, both back to back and separated by idle cycles. A reset in the middle of the run, followed by the same fault stream, checks that the sequence starts again from the seed.

// File: rtl/rwp_pkg.sv
// Package: shared widths and the access-kind encoding for the refill way picker.
// Assumes a 32-bit status word with the page number at the top.
package rwp_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned KIND_W   = 2;
    localparam int unsigned KIND_LSB = 8;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/rwp_rand_shift.sv
// Module: right-shifting pseudo-random register that steps only when asked.
// Feedback is the parity of the state masked by TAPS and enters at the top bit.
// Assumes step_i is a clean single-cycle qualifier.
module rwp_rand_shift #(
    parameter int unsigned         W    = 16,
    parameter logic [W-1:0]        SEED = 16'hCCCC,
    parameter logic [W-1:0]        TAPS = 16'h8805
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic         fb;

    // Parity of the tapped bits.
    always_comb fb = ^(state_q & TAPS);

    // Load the seed on reset; shift right with feedback on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= SEED;
        else if (step_i) state_q <= {fb, state_q[W-1:1]};
    end

    assign state_o = state_q;

    // R3: the state holds on cycles without a step.
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
    // R2: the lower bits are the previous upper bits after a step.
    a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> state_q[W-2:0] == $past(state_q[W-1:1]));
    // R2: a non-zero seed never reaches the all-zero lockup state.
    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/rwp_way_pick.sv
// Module: chooses the refill way.
// A permission fault reuses the way that hit; a real miss takes the random bits.
// Purely combinational; the caller registers the result.
module rwp_way_pick #(
    parameter int unsigned WAY_W = 2
) (
    input  logic             prot_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic [WAY_W-1:0] rand_way_i,
    output logic [WAY_W-1:0] way_o
);
    // Select the source of the way.
    always_comb way_o = prot_i ? hit_way_i : rand_way_i;
endmodule

// File: rtl/rwp_status.sv
// Module: the selection and cause status words, both written on a fault edge.
// The selection word is rebuilt from zero each time.
// The cause word only replaces its page, kind and pid fields, so the bits
// between them keep their previous value.
module rwp_status
    import rwp_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned WAY_W = 2,
    parameter int unsigned VPN_W = 19,
    parameter int unsigned PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [WAY_W-1:0] way_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [PID_W-1:0] pid_i,
    input  acc_kind_e        kind_i,
    output logic [REG_W-1:0] sel_o,
    output logic [REG_W-1:0] cause_o
);
    localparam int unsigned VPN_LSB = REG_W - VPN_W;

    logic [REG_W-1:0] sel_q, cause_q, sel_d, cause_d;

    // Build the next selection word: index and way, everything else zero.
    always_comb begin
        sel_d = '0;
        sel_d[IDX_W-1:0]     = vpn_i[IDX_W-1:0];
        sel_d[IDX_W +: WAY_W] = way_i;
    end

    // Build the next cause word by replacing only its three fields.
    always_comb begin
        cause_d = cause_q;
        cause_d[PID_W-1:0]          = pid_i;
        cause_d[KIND_LSB +: KIND_W] = kind_i;
        cause_d[VPN_LSB +: VPN_W]   = vpn_i;
    end

    // Status registers: clear on reset, load on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            cause_q <= '0;
        end else if (upd_i) begin
            sel_q   <= sel_d;
            cause_q <= cause_d;
        end
    end

    assign sel_o   = sel_q;
    assign cause_o = cause_q;

    // R8: both words hold on cycles without a fault.
    a_r8_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(sel_q) && $stable(cause_q));
    // R8: the bits between the kind and page fields never change.
    a_r8_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> cause_q[VPN_LSB-1:KIND_LSB+KIND_W] ==
                  $past(cause_q[VPN_LSB-1:KIND_LSB+KIND_W]));
    // R7: the fields of the cause word follow the fault inputs.
    a_r7_cause_fields: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> cause_q[PID_W-1:0] == $past(pid_i) &&
                  cause_q[REG_W-1:VPN_LSB] == $past(vpn_i));
endmodule

// File: rtl/refill_way_picker.sv
// Module: top of the refill way picker.
// On each fault strobe it records the selection and cause words and steps the
// random register. Assumes fault_i is high for one cycle per fault and that
// hit_way_i is valid whenever prot_fault_i is high.
module refill_way_picker
    import rwp_pkg::*;
#(
    parameter int unsigned   RAND_W = 16,
    parameter logic [15:0]   SEED   = 16'hCCCC,
    parameter logic [15:0]   TAPS   = 16'h8805,
    parameter int unsigned   WAYS   = 4,
    parameter int unsigned   IDX_W  = 4,
    parameter int unsigned   VPN_W  = 19,
    parameter int unsigned   PID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [18:0]       vpn_i,
    input  logic [7:0]        pid_i,
    input  logic              prot_fault_i,
    input  logic [1:0]        hit_way_i,
    output logic [31:0]       sel_o,
    output logic [31:0]       cause_o,
    output logic [15:0]       rand_state_o
);
    localparam int unsigned WAY_W = $clog2(WAYS);

    logic [RAND_W-1:0] rand_q;
    logic [WAY_W-1:0]  way;
    acc_kind_e         kind;

    // Interpret the raw access-kind code.
    always_comb kind = acc_kind_e'(acc_kind_i);

    rwp_rand_shift #(.W(RAND_W), .SEED(SEED), .TAPS(TAPS)) u_rand (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (fault_i),
        .state_o (rand_q)
    );

    rwp_way_pick #(.WAY_W(WAY_W)) u_pick (
        .prot_i     (prot_fault_i),
        .hit_way_i  (hit_way_i),
        .rand_way_i (rand_q[WAY_W-1:0]),
        .way_o      (way)
    );

    rwp_status #(.IDX_W(IDX_W), .WAY_W(WAY_W), .VPN_W(VPN_W), .PID_W(PID_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (fault_i),
        .way_i   (way),
        .vpn_i   (vpn_i),
        .pid_i   (pid_i),
        .kind_i  (kind),
        .sel_o   (sel_o),
        .cause_o (cause_o)
    );

    assign rand_state_o = rand_q;

    // R4: a real miss records the random bits from before the step.
    a_r4_miss_way: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i && !prot_fault_i |=> sel_o[IDX_W +: WAY_W] == $past(rand_q[WAY_W-1:0]));
    // R5: a permission fault records the way that hit.
    a_r5_prot_way: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i && prot_fault_i |=> sel_o[IDX_W +: WAY_W] == $past(hit_way_i));
    // R6: the index follows the low page bits.
    a_r6_index: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> sel_o[IDX_W-1:0] == $past(vpn_i[IDX_W-1:0]));
endmodule

// File: tb/refill_way_picker_test.sv
module refill_way_picker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_i = 1'b0;
    logic [1:0]  acc_kind_i = 2'd0;
    logic [18:0] vpn_i = '0;
    logic [7:0]  pid_i = '0;
    logic        prot_fault_i = 1'b0;
    logic [1:0]  hit_way_i = 2'd0;
    logic [31:0] sel_o, cause_o;
    logic [15:0] rand_state_o;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // Reference model state.
    int unsigned m_rand, m_sel, m_cause;

    refill_way_picker uut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .acc_kind_i(acc_kind_i),
        .vpn_i(vpn_i), .pid_i(pid_i), .prot_fault_i(prot_fault_i),
        .hit_way_i(hit_way_i), .sel_o(sel_o), .cause_o(cause_o),
        .rand_state_o(rand_state_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned next_rand(input int unsigned s);
        int unsigned p = 0;
        int unsigned mask = 32'h8805;
        for (int i = 0; i < 16; i++)
            if (((s >> i) & 1) && ((mask >> i) & 1)) p = p ^ 1;
        return ((s >> 1) | (p << 15)) & 32'hFFFF;
    endfunction

    function automatic void model_reset();
        m_rand = 32'hCCCC; m_sel = 0; m_cause = 0;
    endfunction

    // One cycle: drive at the falling edge, update the model at the rising
    // edge, compare at the next falling edge.
    task automatic step(input bit f, input int unsigned kind, input int unsigned vpn,
                        input int unsigned pid, input bit prot, input int unsigned hw,
                        input string tag);
        int unsigned way;
        fault_i = f; acc_kind_i = kind[1:0]; vpn_i = vpn[18:0];
        pid_i = pid[7:0]; prot_fault_i = prot; hit_way_i = hw[1:0];
        @(posedge clk);
        if (f) begin
            way     = prot ? hw : (m_rand & 3);
            m_sel   = (vpn & 15) | (way << 4);
            m_cause = (m_cause & 32'h0000_1C00) | ((vpn & 32'h7FFFF) << 13)
                      | ((kind & 3) << 8) | (pid & 255);
            m_rand  = next_rand(m_rand);
        end
        @(negedge clk);
        chk(f ? "R2" : "R3", "rand_state", rand_state_o, m_rand);
        chk(tag, "sel", sel_o, m_sel);
        chk(f ? "R7" : "R8", "cause", cause_o, m_cause);
        chk("R8", "cause gap", (cause_o >> 10) & 7, 0);
        fault_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fault_i = 1'b0;
        @(posedge clk); @(negedge clk);
        model_reset();
        chk("R1", "reset rand", rand_state_o, 32'hCCCC);
        chk("R1", "reset sel", sel_o, 0);
        chk("R1", "reset cause", cause_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R3/R8: idle cycles leave everything alone.
        for (int i = 0; i < 4; i++) step(0, 1, 19'h7FFFF, 8'hFF, 0, 3, "R8");
        // R4/R6/R7: misses with every access kind and varied pages.
        for (int i = 0; i < 40; i++)
            step(1, i % 3, (i * 32'h2F1B3) & 32'h7FFFF, (i * 37) & 255, 0, 3, "R4");
        // R5: permission faults with each hit way, idle cycles between them.
        for (int w = 0; w < 4; w++) begin
            step(1, 1, 19'h4_0000 | w, 8'hA5, 1, w, "R5");
            step(0, 0, 0, 0, 0, 0, "R8");
        end
        // R9: back-to-back faults, alternating miss and permission fault.
        for (int i = 0; i < 24; i++)
            step(1, 2, (i * 32'h1357) & 32'h7FFFF, i, i[0], 3 - (i & 3), "R9");
        // R6: page values with all-ones and all-zero index bits.
        step(1, 0, 19'h7FFFF, 8'h00, 0, 0, "R6");
        step(1, 0, 19'h7FFF0, 8'hFF, 1, 2, "R6");
        // Mixed random stream.
        for (int i = 0; i < 200; i++)
            step($urandom_range(1, 0), $urandom_range(2, 0), $urandom_range(32'h7FFFF, 0),
                 $urandom_range(255, 0), $urandom_range(1, 0), $urandom_range(3, 0), "R4");
        // R1: reset in mid-run, then the sequence starts again from the seed.
        do_reset();
        for (int i = 0; i < 20; i++) step(1, 0, i, 1, 0, 0, "R1");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule